// File: doc/BRIEF.md
# Snoop Coherence Resolver

This block settles one bus transaction against the line state of four peer caches and their writeback buffers. The bus side offers a command (read-shared GET, read-exclusive GETX, UPGRADE of a shared copy, or WRITEBACK), a line address, the ID of the requesting peer and a DMA marker. Each peer's cache array is modelled as three input bits for the addressed line: held exclusive, held shared, and present in that peer's writeback buffer.

The block scans the peers from the lowest ID upward and stops at the first one that can supply the line. It reports the snoop action for each peer: write back and downgrade, extract, invalidate, or free the writeback entry. It also reports a result word and a routing decision. A line sourced cache-to-cache is answered after the memory latency plus a dirty penalty. A plain UPGRADE completes at once. Every other outcome is pushed to the memory queue. A GETX or UPGRADE also produces a mask of queued UPGRADEs to the same line, and each of those must be refused (NAKed). Only one transaction is in flight at a time.

Top module: `snoop_resolver`

## Requirements
- R1: For GET (cmd 0), the lowest-ID scanned peer holding the line exclusive gets `act_wbdown` set. The scan stops there, so higher peers get no action.
- R2: For GET or GETX, a scanned peer whose writeback buffer holds the line gets `act_wbfree` set and ends the scan. The result is cache-to-cache. If the same peer also holds the line exclusive, the exclusive action takes its place.
- R3: For GETX (cmd 1), the first scanned exclusive holder gets `act_extract` set and the scan stops. Every shared holder scanned before that point gets `act_inval`, and the scan continues past it.
- R4: For UPGRADE (cmd 2), every non-requester peer holding the line shared gets `act_inval`. No extract, downgrade or buffer free occurs, and the route is never cache-to-cache.
- R5: For GETX or UPGRADE only, `nak_mask[j]` is set for each queue slot j that is valid, marked as an upgrade, and holds the request address. For GET and WRITEBACK the mask is zero.
- R6: The requester's own peer slot is skipped during the scan. The exception is a DMA GET or GETX, which scans the requester's slot too.
- R7: Routing: a cache-to-cache result sets `route_c2c`, and `c2c_done` pulses exactly MEM_LAT+DIRTY_PEN cycles after `res_valid`. A non-cache UPGRADE sets `route_now`. Everything else, including WRITEBACK (cmd 3, which snoops nothing), sets `route_mem`. Exactly one route bit is set.
- R8: `res_flags` bit 0 = memory-sourced, bit 1 = cache-sourced, bit 2 = downgrade, bit 3 = invalidate. A cache-to-cache result sets bits 1 and 2 and clears bit 0. Any other result sets bit 0. Bit 3 is set when any invalidate or extract occurred, or on a GETX served from a writeback buffer.
- R9: A request is taken on a cycle with `req_valid` and `req_ready` both high. `res_valid` is high for exactly the next cycle. `req_ready` stays low until that cycle ends, or for a cache-to-cache result until the `c2c_done` cycle ends. After reset `req_ready` is high and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transaction offered |
| req_ready | output | 1 | Block idle, can take a transaction |
| req_cmd | input | 2 | 0 GET, 1 GETX, 2 UPGRADE, 3 WRITEBACK |
| req_addr | input | AW | Line address |
| req_src | input | IDW | Requesting peer ID |
| req_dma | input | 1 | DMA-type request |
| peer_excl | input | NPEER | Peer holds line exclusive |
| peer_shr | input | NPEER | Peer holds line shared |
| peer_wbhit | input | NPEER | Line sits in peer's writeback buffer |
| pend_valid | input | QDEPTH | Queue slot occupied |
| pend_upg | input | QDEPTH | Queue slot is an UPGRADE |
| pend_addr | input | QDEPTH*AW | Queue slot addresses, slot j at bits j*AW |
| res_valid | output | 1 | Resolution outputs valid |
| act_wbdown | output | NPEER | Write back and downgrade, per peer |
| act_extract | output | NPEER | Extract and invalidate, per peer |
| act_inval | output | NPEER | Invalidate shared copy, per peer |
| act_wbfree | output | NPEER | Supply and free writeback entry, per peer |
| res_flags | output | 4 | Result word |
| nak_mask | output | QDEPTH | Queued upgrades to refuse |
| route_mem | output | 1 | Send to memory queue |
| route_now | output | 1 | Complete immediately |
| route_c2c | output | 1 | Delayed cache-to-cache reply |
| c2c_done | output | 1 | Cache-to-cache reply due |

## Verification
The actions, flags, NAK mask and route are registered at the accepting edge. They are therefore due in the single cycle after acceptance, and the bench samples them at the falling edge of that cycle. `c2c_done` is due MEM_LAT+DIRTY_PEN cycles after that result cycle. The bench counts falling edges from the result cycle to the pulse, and checks that `req_ready` stays low across the whole wait. It also checks that `req_ready` returns on the next cycle after the pulse. Inputs change only at falling edges, so every sample sees settled registered values.

// File: rtl/snoop_resolver.sv
module snoop_resolver #(
  parameter int NPEER     = 4,
  parameter int QDEPTH    = 4,
  parameter int AW        = 32,
  parameter int MEM_LAT   = 6,
  parameter int DIRTY_PEN = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_cmd,
  input  logic [AW-1:0]        req_addr,
  input  logic [$clog2(NPEER)-1:0] req_src,
  input  logic                 req_dma,
  input  logic [NPEER-1:0]     peer_excl,
  input  logic [NPEER-1:0]     peer_shr,
  input  logic [NPEER-1:0]     peer_wbhit,
  input  logic [QDEPTH-1:0]    pend_valid,
  input  logic [QDEPTH-1:0]    pend_upg,
  input  logic [QDEPTH*AW-1:0] pend_addr,
  output logic                 res_valid,
  output logic [NPEER-1:0]     act_wbdown,
  output logic [NPEER-1:0]     act_extract,
  output logic [NPEER-1:0]     act_inval,
  output logic [NPEER-1:0]     act_wbfree,
  output logic [3:0]           res_flags,
  output logic [QDEPTH-1:0]    nak_mask,
  output logic                 route_mem,
  output logic                 route_now,
  output logic                 route_c2c,
  output logic                 c2c_done
);
  localparam int IDW   = $clog2(NPEER);
  localparam int DELAY = MEM_LAT + DIRTY_PEN;
  localparam int CW    = $clog2(DELAY + 1);

  localparam logic [1:0] CMD_GET  = 2'd0;
  localparam logic [1:0] CMD_GETX = 2'd1;
  localparam logic [1:0] CMD_UPG  = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_RES, S_WAIT} st_t;
  st_t st;

  logic [1:0]       r_cmd;
  logic [IDW-1:0]   r_src;
  logic             r_dma;
  logic [1:0]       r_route;
  logic [CW-1:0]    cnt;

  logic [NPEER-1:0] n_wd, n_xt, n_iv, n_wf;
  logic             n_c2c, stop, scan_self;
  logic [3:0]       n_flags;
  logic [1:0]       n_route;
  logic [QDEPTH-1:0] n_nak;

  wire is_read    = (req_cmd == CMD_GET) || (req_cmd == CMD_GETX);
  wire kills_upg  = (req_cmd == CMD_GETX) || (req_cmd == CMD_UPG);
  assign scan_self = req_dma && is_read;

  always_comb begin
    n_wd = '0; n_xt = '0; n_iv = '0; n_wf = '0; stop = 1'b0;
    for (int i = 0; i < NPEER; i++) begin
      if (!stop && (scan_self || i != int'(req_src))) begin
        case (req_cmd)
          CMD_GET: begin
            if (peer_excl[i]) begin
              n_wd[i] = 1'b1; stop = 1'b1;
            end else if (peer_wbhit[i]) begin
              n_wf[i] = 1'b1; stop = 1'b1;
            end
          end
          CMD_GETX: begin
            if (peer_excl[i]) begin
              n_xt[i] = 1'b1; stop = 1'b1;
            end else begin
              if (peer_shr[i]) n_iv[i] = 1'b1;
              if (peer_wbhit[i]) begin
                n_wf[i] = 1'b1; stop = 1'b1;
              end
            end
          end
          CMD_UPG: if (peer_shr[i]) n_iv[i] = 1'b1;
          default: ;
        endcase
      end
    end
    n_c2c = stop;
  end

  always_comb begin
    n_flags[0] = !n_c2c;
    n_flags[1] = n_c2c;
    n_flags[2] = n_c2c;
    n_flags[3] = (|n_iv) || (|n_xt) || ((req_cmd == CMD_GETX) && (|n_wf));
    if (n_c2c)                n_route = 2'd2;
    else if (req_cmd == CMD_UPG) n_route = 2'd1;
    else                      n_route = 2'd0;
  end

  for (genvar j = 0; j < QDEPTH; j++) begin : g_nak
    assign n_nak[j] = kills_upg && pend_valid[j] && pend_upg[j] &&
                      (pend_addr[j*AW +: AW] == req_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      r_cmd       <= '0;
      r_src       <= '0;
      r_dma       <= 1'b0;
      r_route     <= '0;
      act_wbdown  <= '0;
      act_extract <= '0;
      act_inval   <= '0;
      act_wbfree  <= '0;
      res_flags   <= '0;
      nak_mask    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st          <= S_RES;
          r_cmd       <= req_cmd;
          r_src       <= req_src;
          r_dma       <= req_dma;
          r_route     <= n_route;
          act_wbdown  <= n_wd;
          act_extract <= n_xt;
          act_inval   <= n_iv;
          act_wbfree  <= n_wf;
          res_flags   <= n_flags;
          nak_mask    <= n_nak;
        end
        S_RES: begin
          if (r_route == 2'd2) begin
            st  <= S_WAIT;
            cnt <= CW'(DELAY - 1);
          end else begin
            st <= S_IDLE;
          end
        end
        S_WAIT: begin
          if (cnt == '0) st <= S_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign res_valid = (st == S_RES);
  assign c2c_done  = (st == S_WAIT) && (cnt == '0);
  assign route_mem = (r_route == 2'd0);
  assign route_now = (r_route == 2'd1);
  assign route_c2c = (r_route == 2'd2);
endmodule

module snoop_resolver_chk #(
  parameter int NPEER  = 4,
  parameter int QDEPTH = 4,
  parameter int DELAY  = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 res_valid,
  input logic [NPEER-1:0]     act_wbdown,
  input logic [NPEER-1:0]     act_extract,
  input logic [NPEER-1:0]     act_inval,
  input logic [NPEER-1:0]     act_wbfree,
  input logic [3:0]           res_flags,
  input logic [QDEPTH-1:0]    nak_mask,
  input logic                 route_mem,
  input logic                 route_now,
  input logic                 route_c2c,
  input logic                 c2c_done,
  input logic [1:0]           r_cmd,
  input logic [$clog2(NPEER)-1:0] r_src,
  input logic                 r_dma
);
  localparam int CW = $clog2(DELAY + 2);
  logic [CW-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wcnt <= '0;
    else if (res_valid && route_c2c) wcnt <= CW'(1);
    else if (c2c_done)               wcnt <= '0;
    else if (wcnt != '0)             wcnt <= wcnt + 1'b1;
  end

  p_one_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(act_wbdown));
  p_single_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones({act_wbdown, act_extract, act_wbfree}) <= 1);
  p_source_is_c2c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (|{act_wbdown, act_extract, act_wbfree}) |-> route_c2c);
  p_getx_extract_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && r_cmd != 2'd1 |-> act_extract == '0);
  p_upg_no_c2c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && r_cmd == 2'd2 |-> !route_c2c && route_now);
  p_nak_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (r_cmd == 2'd0 || r_cmd == 2'd3) |-> nak_mask == '0);
  p_skip_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !(r_dma && r_cmd[1] == 1'b0) |->
      !act_wbdown[r_src] && !act_extract[r_src] && !act_inval[r_src] && !act_wbfree[r_src]);
  p_route_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({route_mem, route_now, route_c2c}));
  p_c2c_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    c2c_done |-> wcnt == CW'(DELAY));
  p_c2c_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && route_c2c |-> res_flags[1] && res_flags[2] && !res_flags[0]);
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid && !req_ready);
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    c2c_done |=> req_ready);
endmodule

bind snoop_resolver snoop_resolver_chk #(
  .NPEER(NPEER), .QDEPTH(QDEPTH), .DELAY(MEM_LAT + DIRTY_PEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .act_wbdown(act_wbdown), .act_extract(act_extract),
  .act_inval(act_inval), .act_wbfree(act_wbfree), .res_flags(res_flags),
  .nak_mask(nak_mask), .route_mem(route_mem), .route_now(route_now),
  .route_c2c(route_c2c), .c2c_done(c2c_done), .r_cmd(r_cmd), .r_src(r_src),
  .r_dma(r_dma)
);

// File: tb/tb_snoop_resolver.sv
module tb_snoop_resolver;
  localparam int NP = 4, QD = 4, AW = 32, DLY = 6 + 3, NV = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_dma = 1'b0;
  logic [1:0] req_cmd = '0, req_src = '0;
  logic [AW-1:0] req_addr = '0;
  logic [NP-1:0] peer_excl = '0, peer_shr = '0, peer_wbhit = '0;
  logic [QD-1:0] pend_valid = '0, pend_upg = '0;
  logic [QD*AW-1:0] pend_addr = '0;
  logic res_valid, route_mem, route_now, route_c2c, c2c_done;
  logic [NP-1:0] act_wbdown, act_extract, act_inval, act_wbfree;
  logic [3:0] res_flags;
  logic [QD-1:0] nak_mask;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  snoop_resolver dut (.*);

  // {cmd,src,dma,excl,shr,wb, exp wbdown,extract,inval,wbfree,flags,route}
  localparam logic [38:0] VEC [NV] = '{
    {2'd0,2'd0,1'b0,4'b0100,4'b0000,4'b0000, 4'b0100,4'b0000,4'b0000,4'b0000,4'b0110,2'd2},
    {2'd0,2'd0,1'b0,4'b0110,4'b0000,4'b0000, 4'b0010,4'b0000,4'b0000,4'b0000,4'b0110,2'd2},
    {2'd0,2'd1,1'b0,4'b0010,4'b0000,4'b1000, 4'b0000,4'b0000,4'b0000,4'b1000,4'b0110,2'd2},
    {2'd0,2'd1,1'b1,4'b0010,4'b0000,4'b0000, 4'b0010,4'b0000,4'b0000,4'b0000,4'b0110,2'd2},
    {2'd0,2'd0,1'b0,4'b0000,4'b0000,4'b0000, 4'b0000,4'b0000,4'b0000,4'b0000,4'b0001,2'd0},
    {2'd1,2'd0,1'b0,4'b0000,4'b1010,4'b0000, 4'b0000,4'b0000,4'b1010,4'b0000,4'b1001,2'd0},
    {2'd1,2'd0,1'b0,4'b0100,4'b1010,4'b0000, 4'b0000,4'b0100,4'b0010,4'b0000,4'b1110,2'd2},
    {2'd1,2'd3,1'b0,4'b0000,4'b0010,4'b0100, 4'b0000,4'b0000,4'b0010,4'b0100,4'b1110,2'd2},
    {2'd2,2'd2,1'b0,4'b0000,4'b1111,4'b0000, 4'b0000,4'b0000,4'b1011,4'b0000,4'b1001,2'd1},
    {2'd2,2'd0,1'b0,4'b0000,4'b0001,4'b0000, 4'b0000,4'b0000,4'b0000,4'b0000,4'b0001,2'd1},
    {2'd3,2'd1,1'b0,4'b0100,4'b0010,4'b1000, 4'b0000,4'b0000,4'b0000,4'b0000,4'b0001,2'd0},
    {2'd0,2'd0,1'b0,4'b0001,4'b1110,4'b0000, 4'b0000,4'b0000,4'b0000,4'b0000,4'b0001,2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] route_code();
    return route_c2c ? 2'd2 : route_now ? 2'd1 : route_mem ? 2'd0 : 2'd3;
  endfunction

  task automatic issue(input logic [1:0] cmd, input logic [1:0] src, input logic dma,
                       input logic [3:0] ex, input logic [3:0] sh, input logic [3:0] wb,
                       input logic [AW-1:0] addr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cmd = cmd; req_src = src; req_dma = dma;
    peer_excl = ex; peer_shr = sh; peer_wbhit = wb; req_addr = addr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 result one cycle after accept", {31'd0, res_valid}, 32'd1);
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    bit ready_seen = 1'b0;
    while (!c2c_done && n < 100) begin
      @(negedge clk);
      n++;
      if (req_ready) ready_seen = 1'b1;
    end
    chk(tag, n, DLY);
    chk("R9 ready low while reply pending", {31'd0, ready_seen}, 32'd0);
    @(negedge clk);
    chk("R9 ready after reply", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R9 reset res_valid", {31'd0, res_valid}, 32'd0);
    chk("R7 reset c2c_done", {31'd0, c2c_done}, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [38:0] e;
      string tag;
      e = VEC[v];
      tag = (e[38:37] == 2'd0) ? "R1 R2 R6 GET actions" :
            (e[38:37] == 2'd1) ? "R3 R2 GETX actions" :
            (e[38:37] == 2'd2) ? "R4 R6 UPGRADE actions" : "R7 WRITEBACK actions";
      issue(e[38:37], e[36:35], e[34], e[33:30], e[29:26], e[25:22], 32'h1000);
      chk(tag, {act_wbdown, act_extract, act_inval, act_wbfree}, {16'd0, e[21:6]});
      chk("R8 result flags", {28'd0, res_flags}, {28'd0, e[5:2]});
      chk("R7 route", {30'd0, route_code()}, {30'd0, e[1:0]});
      if (e[1:0] == 2'd2) wait_done("R7 cache reply delay");
    end

    pend_valid = 4'b0111; pend_upg = 4'b1011;
    pend_addr = {32'h0000_2000, 32'h0000_2000, 32'h0000_3000, 32'h0000_2000};
    issue(2'd1, 2'd0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 32'h2000);
    chk("R5 GETX naks matching queued upgrades", {28'd0, nak_mask}, 32'h1);
    issue(2'd2, 2'd1, 1'b0, 4'b0000, 4'b0000, 4'b0000, 32'h3000);
    chk("R5 UPGRADE naks matching queued upgrade", {28'd0, nak_mask}, 32'h2);
    issue(2'd0, 2'd0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 32'h2000);
    chk("R5 GET naks nothing", {28'd0, nak_mask}, 32'h0);
    issue(2'd3, 2'd0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 32'h2000);
    chk("R5 WRITEBACK naks nothing", {28'd0, nak_mask}, 32'h0);

    issue(2'd1, 2'd2, 1'b1, 4'b0100, 4'b0000, 4'b0000, 32'h40);
    chk("R6 DMA GETX scans own slot", {28'd0, act_extract}, 32'h4);
    wait_done("R7 cache reply delay DMA");
    issue(2'd2, 2'd2, 1'b1, 4'b0000, 4'b0100, 4'b0000, 32'h40);
    chk("R6 DMA UPGRADE still skips own slot", {28'd0, act_inval}, 32'h0);
    issue(2'd0, 2'd3, 1'b0, 4'b1000, 4'b0000, 4'b1000, 32'h40);
    chk("R2 R6 own exclusive and buffer skipped", {31'd0, route_mem}, 32'd1);
    issue(2'd0, 2'd0, 1'b0, 4'b0010, 4'b0000, 4'b0010, 32'h40);
    chk("R2 exclusive takes precedence over buffer", {act_wbdown, act_wbfree}, 32'h20);
    wait_done("R7 cache reply delay precedence");

    @(negedge clk);
    chk("R9 idle between requests", {31'd0, res_valid}, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule